// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master for external Ethernet PHYs. Host software reaches it through a small 32-bit register window. It turns certain register writes into serial management frames on an MDC/MDIO pair. Both the original short framing, used for gigabit PHYs, and the extended framing, used for 10G devices, are supported. A single mode bit in the status word selects between them. The serial clock MDC is derived from the system clock by a divider that software programs. The bidirectional MDIO line is presented as separate output, output-enable and input signals, so the pad can sit outside the block.

Frames start as a side effect of register writes:

- A data-register write sends a write frame.
- A control write with the read bit set sends a read frame.
- An address-register write in extended mode sends an address frame.

While a frame runs, the busy flag is set. After a read, the captured 16 bits appear in the data register. A read error is flagged when the PHY fails to pull the line low in the turnaround.

Top module: `mgmt_mdio_master`

## Requirements
- R1: Registers sit at word indices 12 (status), 13 (control), 14 (data) and 15 (address); all other indices read 0.
  - Status layout: bit 0 busy, bit 1 read error, bit 6 framing mode, bits 15:8 divider.
  - Control layout: bits 4:0 device/register address, bits 9:5 port address, bit 10 preamble disable, bit 11 scan enable.
  - Control bit 15 reads back as 0.
  - Every register resets to 0.
- R2: MDC stays low while idle. During a frame each MDC half period lasts N system clocks, where N is the divider field; a field of 0 acts as 1.
- R3: Each frame starts with 32 one-bits driven on MDIO unless control bit 10 was set when the frame was launched, in which case the frame starts directly with the start bits.
- R4: With status bit 6 clear, frames use start 01, opcode 10 for read and 01 for write, then 5-bit port, 5-bit register address, turnaround and 16 data bits, all MSB first. A write drives turnaround 10.
- R5: With status bit 6 set, frames use start 00, opcode 00 for address, 01 for write and 11 for read. An address frame carries the address register value in its 16 data bits.
- R6: MDIO output and output-enable change only while MDC is low, following its falling edge. The input is sampled when MDC rises.
- R7: In a read frame the master releases MDIO (output-enable low) from the first turnaround bit to the end of the frame. The 16 bits sampled after the turnaround are returned in data-register bits 15:0.
- R8: A read in which MDIO is high in the second turnaround bit sets status bit 1. The flag clears when the next frame is launched.
- R9: Busy (status bit 0, mirrored in data-register bit 31) is set from the cycle after a launch until the frame ends.
- R10: While busy, three kinds of write are dropped entirely and leave every register unchanged: a data write, an address write, and a control write with bit 15 set.
- R11: An address-register write with status bit 6 clear only stores the value and launches no frame.
- R12: Setting the scan bit is stored and read back but starts no bus activity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word index |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
The bench builds the block with its default parameters: a 4-bit word index and a 32-bit preamble. It programs divider values 1 to 3, so a full frame of 64 bits spans 128 to 384 system clocks. This keeps every framing mode, a preamble-less frame, a read error and a dropped write-while-busy within a short run. A PHY model answers read frames according to their bit position. The bench compares every bit, together with its output-enable, against the framing rules.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int REG_STAT = 12;
    localparam int REG_CTRL = 13;
    localparam int REG_DATA = 14;
    localparam int REG_ADDR = 15;

    localparam int DIV_W      = 8;
    localparam int PAYLOAD_W  = 16;
    localparam int FIELD_W    = 5;

    localparam int STAT_C45_BIT  = 6;
    localparam int STAT_DIV_LSB  = 8;
    localparam int CTL_PORT_LSB  = 5;
    localparam int CTL_NOPRE_BIT = 10;
    localparam int CTL_SCAN_BIT  = 11;
    localparam int CTL_READ_BIT  = 15;

    typedef enum logic [1:0] {
        KIND_ADDR  = 2'd0,
        KIND_WRITE = 2'd1,
        KIND_READ  = 2'd2
    } frame_kind_t;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_PRE  = 2'd1,
        ENG_BODY = 2'd2
    } eng_state_t;

    typedef struct packed {
        logic [1:0]           st;
        logic [1:0]           op;
        logic [FIELD_W-1:0]   port;
        logic [FIELD_W-1:0]   dev;
        logic [1:0]           ta;
        logic [PAYLOAD_W-1:0] payload;
    } mdio_frame_t;

    typedef struct packed {
        mdio_frame_t frame;
        logic        is_read;
        logic        pre_en;
    } mdio_req_t;

    function automatic mdio_frame_t build_frame(
        input frame_kind_t          kind,
        input logic                 ext,
        input logic [FIELD_W-1:0]   port,
        input logic [FIELD_W-1:0]   dev,
        input logic [PAYLOAD_W-1:0] payload
    );
        mdio_frame_t f;
        f.st      = ext ? 2'b00 : 2'b01;
        f.port    = port;
        f.dev     = dev;
        f.ta      = 2'b10;
        f.payload = payload;
        unique case (kind)
            KIND_ADDR:  f.op = 2'b00;
            KIND_WRITE: f.op = 2'b01;
            KIND_READ:  f.op = ext ? 2'b11 : 2'b10;
            default:    f.op = 2'b01;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             mdc,
    output logic             mdc_rise,
    output logic             mdc_fall
);

    logic [DIV_W-1:0] cnt_q;
    logic             hit;

    assign hit      = (cnt_q == half - DIV_W'(1));
    assign mdc_rise = run && hit && !mdc;
    assign mdc_fall = run && hit && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (hit) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // R2
    idle_mdc_low_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !mdc);

endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 launch,
    input  mdio_req_t            req,
    input  logic [DIV_W-1:0]     div_in,
    input  logic                 mdc,
    input  logic                 mdc_rise,
    input  logic                 mdc_fall,
    input  logic                 mdio_i,
    output logic                 busy,
    output logic [DIV_W-1:0]     half,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 rd_done,
    output logic [PAYLOAD_W-1:0] rd_value,
    output logic                 rd_err
);

    localparam int BODY_LEN = $bits(mdio_frame_t);
    localparam int IDX_W    = $clog2(BODY_LEN);
    localparam int PRE_W    = $clog2(PRE_LEN + 1);
    localparam int TA_FIRST = BODY_LEN - PAYLOAD_W - 2;
    localparam int TA_LAST  = TA_FIRST + 1;

    eng_state_t            state_q;
    logic [IDX_W-1:0]      idx_q;
    logic [PRE_W-1:0]      pcnt_q;
    mdio_frame_t           frame_q;
    logic                  rd_q;
    logic                  err_q;
    logic [PAYLOAD_W-1:0]  shift_q;
    logic [DIV_W-1:0]      half_q;
    logic                  last_bit;
    logic                  released;

    assign busy     = (state_q != ENG_IDLE);
    assign half     = half_q;
    assign rd_value = shift_q;
    assign rd_err   = err_q;
    assign last_bit = (idx_q == IDX_W'(BODY_LEN - 1));
    assign released = rd_q && (idx_q >= IDX_W'(TA_FIRST));
    assign rd_done  = (state_q == ENG_BODY) && mdc_fall && last_bit && rd_q;

    always_comb begin
        mdio_o  = 1'b1;
        mdio_oe = 1'b0;
        unique case (state_q)
            ENG_PRE: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b1;
            end
            ENG_BODY: begin
                mdio_o  = frame_q[IDX_W'(BODY_LEN - 1) - idx_q];
                mdio_oe = !released;
            end
            default: begin
                mdio_o  = 1'b1;
                mdio_oe = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            idx_q   <= '0;
            pcnt_q  <= '0;
            frame_q <= '0;
            rd_q    <= 1'b0;
            err_q   <= 1'b0;
            shift_q <= '0;
            half_q  <= DIV_W'(1);
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (launch) begin
                        frame_q <= req.frame;
                        rd_q    <= req.is_read;
                        err_q   <= 1'b0;
                        idx_q   <= '0;
                        pcnt_q  <= '0;
                        half_q  <= (div_in == '0) ? DIV_W'(1) : div_in;
                        state_q <= req.pre_en ? ENG_PRE : ENG_BODY;
                    end
                end
                ENG_PRE: begin
                    if (mdc_fall) begin
                        if (pcnt_q == PRE_W'(PRE_LEN - 1)) begin
                            state_q <= ENG_BODY;
                        end else begin
                            pcnt_q <= pcnt_q + PRE_W'(1);
                        end
                    end
                end
                ENG_BODY: begin
                    if (mdc_rise && rd_q) begin
                        if (idx_q == IDX_W'(TA_LAST)) begin
                            err_q <= mdio_i;
                        end
                        if (idx_q > IDX_W'(TA_LAST)) begin
                            shift_q <= {shift_q[PAYLOAD_W-2:0], mdio_i};
                        end
                    end
                    if (mdc_fall) begin
                        if (last_bit) begin
                            state_q <= ENG_IDLE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // R6
    mdio_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R8
    err_inside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_q) |-> busy);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 busy,
    input  logic                 rd_err,
    input  logic                 rd_done,
    input  logic [PAYLOAD_W-1:0] rd_value,
    output logic                 launch,
    output mdio_req_t            req,
    output logic [DIV_W-1:0]     div
);

    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(REG_CTRL);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(REG_DATA);
    localparam logic [ADDR_W-1:0] A_ADDR = ADDR_W'(REG_ADDR);

    logic [DIV_W-1:0]     div_q;
    logic                 ext_q;
    logic [FIELD_W-1:0]   dev_q;
    logic [FIELD_W-1:0]   port_q;
    logic                 nopre_q;
    logic                 scan_q;
    logic [PAYLOAD_W-1:0] data_q;
    logic [PAYLOAD_W-1:0] addr_q;

    logic wr_stat, wr_ctrl, wr_data, wr_addr;
    logic rd_req, go_read, go_write, go_addr, ctrl_take;
    logic [FIELD_W-1:0] w_dev, w_port;

    assign wr_stat  = bus_wr && (bus_addr == A_STAT);
    assign wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    assign wr_data  = bus_wr && (bus_addr == A_DATA);
    assign wr_addr  = bus_wr && (bus_addr == A_ADDR);
    assign rd_req   = bus_wdata[CTL_READ_BIT];
    assign w_dev    = bus_wdata[FIELD_W-1:0];
    assign w_port   = bus_wdata[CTL_PORT_LSB +: FIELD_W];

    assign go_read   = wr_ctrl && rd_req && !busy;
    assign go_write  = wr_data && !busy;
    assign go_addr   = wr_addr && !busy && ext_q;
    assign ctrl_take = wr_ctrl && !(rd_req && busy);
    assign launch    = go_read || go_write || go_addr;
    assign div       = div_q;

    always_comb begin
        if (go_read) begin
            req.frame   = build_frame(KIND_READ, ext_q, w_port, w_dev, '1);
            req.is_read = 1'b1;
            req.pre_en  = !bus_wdata[CTL_NOPRE_BIT];
        end else if (go_write) begin
            req.frame   = build_frame(KIND_WRITE, ext_q, port_q, dev_q,
                                      bus_wdata[PAYLOAD_W-1:0]);
            req.is_read = 1'b0;
            req.pre_en  = !nopre_q;
        end else begin
            req.frame   = build_frame(KIND_ADDR, 1'b1, port_q, dev_q,
                                      bus_wdata[PAYLOAD_W-1:0]);
            req.is_read = 1'b0;
            req.pre_en  = !nopre_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q   <= '0;
            ext_q   <= 1'b0;
            dev_q   <= '0;
            port_q  <= '0;
            nopre_q <= 1'b0;
            scan_q  <= 1'b0;
            data_q  <= '0;
            addr_q  <= '0;
        end else begin
            if (wr_stat) begin
                div_q <= bus_wdata[STAT_DIV_LSB +: DIV_W];
                ext_q <= bus_wdata[STAT_C45_BIT];
            end
            if (ctrl_take) begin
                dev_q   <= w_dev;
                port_q  <= w_port;
                nopre_q <= bus_wdata[CTL_NOPRE_BIT];
                scan_q  <= bus_wdata[CTL_SCAN_BIT];
            end
            if (wr_data && !busy) begin
                data_q <= bus_wdata[PAYLOAD_W-1:0];
            end else if (rd_done) begin
                data_q <= rd_value;
            end
            if (wr_addr && !busy) begin
                addr_q <= bus_wdata[PAYLOAD_W-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STAT:  bus_rdata = {16'b0, div_q, 1'b0, ext_q, 4'b0, rd_err, busy};
            A_CTRL:  bus_rdata = {16'b0, 4'b0, scan_q, nopre_q, port_q, dev_q};
            A_DATA:  bus_rdata = {busy, 15'b0, data_q};
            A_ADDR:  bus_rdata = {16'b0, addr_q};
            default: bus_rdata = '0;
        endcase
    end

    // R9
    launch_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy);

    // R10
    busy_data_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_data && !rd_done) |=> $stable(data_q));

    // R10
    busy_addr_write_dropped_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_addr) |=> $stable(addr_q));

endmodule

// File: rtl/mgmt_mdio_master.sv
module mgmt_mdio_master
    import mdio_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic                 launch;
    mdio_req_t            req;
    logic [DIV_W-1:0]     div;
    logic [DIV_W-1:0]     half;
    logic                 busy;
    logic                 rd_err;
    logic                 rd_done;
    logic [PAYLOAD_W-1:0] rd_value;
    logic                 mdc_rise;
    logic                 mdc_fall;

    mdio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .rd_err    (rd_err),
        .rd_done   (rd_done),
        .rd_value  (rd_value),
        .launch    (launch),
        .req       (req),
        .div       (div)
    );

    mdio_clkgen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .half     (half),
        .mdc      (mdc),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall)
    );

    mdio_engine #(.PRE_LEN(PRE_LEN)) u_engine (
        .clk      (clk),
        .rst      (rst),
        .launch   (launch),
        .req      (req),
        .div_in   (div),
        .mdc      (mdc),
        .mdc_rise (mdc_rise),
        .mdc_fall (mdc_fall),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .half     (half),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .rd_done  (rd_done),
        .rd_value (rd_value),
        .rd_err   (rd_err)
    );

endmodule

// File: tb/test_mgmt_mdio_master.sv
module test_mgmt_mdio_master;

    localparam int CLK_P = 10;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          mdc, mdio_o, mdio_oe, mdio_i;

    always #(CLK_P/2) clk = ~clk;

    mgmt_mdio_master #(.ADDR_W(AW), .PRE_LEN(32)) i_mgmt_mdio_master (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int tests = 0;
    int fails = 0;
    bit done_flag = 1'b0;

    // kind(2) ext pre_dis port(5) dev(5) value(16) phy_answers div(2)
    localparam logic [32:0] VEC [0:5] = '{
        {2'd1, 1'b0, 1'b0, 5'h03, 5'h1F, 16'hA5C3, 1'b0, 2'd1},
        {2'd2, 1'b0, 1'b0, 5'h11, 5'h02, 16'h1234, 1'b0, 2'd2},
        {2'd2, 1'b0, 1'b1, 5'h11, 5'h02, 16'h1234, 1'b1, 2'd1},
        {2'd0, 1'b1, 1'b1, 5'h1E, 5'h01, 16'h8001, 1'b0, 2'd1},
        {2'd1, 1'b1, 1'b0, 5'h00, 5'h07, 16'hFFFF, 1'b0, 2'd1},
        {2'd2, 1'b1, 1'b0, 5'h0A, 5'h03, 16'hBEEF, 1'b1, 2'd1}
    };

    // bus capture and PHY model
    int   k = 0;
    logic cap_o  [0:127];
    logic cap_oe [0:127];
    time  t_prev = 0, t_cur = 0;
    logic        pv_read = 1'b0, pv_en = 1'b0;
    logic [15:0] pv_data = '0;
    int          pv_pre = 32;
    int          jb;
    logic        phy_bit;
    int          hold_viol = 0;
    logic        prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;

    always @(posedge mdc) begin
        if (k < 128) begin
            cap_o[k]  = mdio_o;
            cap_oe[k] = mdio_oe;
        end
        k = k + 1;
        t_prev = t_cur;
        t_cur  = $time;
    end

    always_comb begin
        phy_bit = 1'b1;
        jb = k - pv_pre;
        if (pv_read && pv_en) begin
            if (jb == 15) phy_bit = 1'b0;
            else if (jb >= 16 && jb < 32) phy_bit = pv_data[31 - jb];
        end
        mdio_i = mdio_oe ? mdio_o : phy_bit;
    end

    always @(negedge clk) begin
        if (!rst && mdc && prev_mdc && (mdio_o != prev_o || mdio_oe != prev_oe))
            hold_viol = hold_viol + 1;
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(12, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [31:0] exp_body(input logic [1:0] kind, input logic ext,
            input logic [4:0] port, input logic [4:0] dev, input logic [15:0] val);
        logic [1:0] op;
        if (kind == 2'd0) op = 2'b00;
        else if (kind == 2'd1) op = 2'b01;
        else op = ext ? 2'b11 : 2'b10;
        return {ext ? 2'b00 : 2'b01, op, port, dev, 2'b10, val};
    endfunction

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(12, r); chk(r == 0, "R1 status reset", r, 0);
        rd(13, r); chk(r == 0, "R1 control reset", r, 0);
        rd(14, r); chk(r == 0, "R1 data reset / R9 idle", r, 0);
        rd(15, r); chk(r == 0, "R1 address reset", r, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R2 idle mdc low", {30'b0, mdc, mdio_oe}, 0);

        // R1 readback of fields
        wr(12, 32'h0000_2A40);
        rd(12, r); chk(r == 32'h0000_2A40, "R1 status readback", r, 32'h0000_2A40);
        wr(13, 32'h0000_0765);
        rd(13, r); chk(r == 32'h0000_0765, "R1 control readback", r, 32'h0000_0765);
        rd(3, r); chk(r == 0, "R1 unused word", r, 0);

        // vector table: R3 R4 R5 R7 R8
        for (int v = 0; v < 6; v++) begin
            logic [1:0] kind; logic ext, pdis, phy; logic [4:0] port, dev;
            logic [15:0] val; logic [1:0] dv; logic [31:0] body;
            int pre, total, bad;
            {kind, ext, pdis, port, dev, val, phy, dv} = VEC[v];
            wr(12, {16'b0, 6'b0, dv, 1'b0, ext, 6'b0});
            wr(13, {21'b0, pdis, port, dev});
            pre = pdis ? 0 : 32;
            pv_pre = pre; pv_read = (kind == 2'd2); pv_en = phy; pv_data = val;
            k = 0;
            if (kind == 2'd0) wr(15, {16'b0, val});
            else if (kind == 2'd1) wr(14, {16'b0, val});
            else wr(13, {16'b0, 1'b1, 4'b0, pdis, port, dev});
            wait_idle();
            total = pre + 32;
            chk(k == total, "R3 bit count", k, total);
            body = exp_body(kind, ext, port, dev, val);
            bad = 0;
            for (int i = 0; i < total && i < 128; i++) begin
                logic eoe, eo; int b;
                b = i - pre;
                if (i < pre) begin eoe = 1'b1; eo = 1'b1; end
                else begin
                    eoe = !(kind == 2'd2 && b >= 14);
                    eo  = body[31 - b];
                end
                if (cap_oe[i] !== eoe || (eoe && cap_o[i] !== eo)) bad = bad + 1;
            end
            if (ext) chk(bad == 0, "R5 frame bits", bad, 0);
            else     chk(bad == 0, "R4 frame bits", bad, 0);
            if (kind == 2'd2) begin
                logic [15:0] ed;
                ed = phy ? val : 16'hFFFF;
                rd(14, r); chk(r == {16'b0, ed}, "R7 read data", r, {16'b0, ed});
                rd(12, r); chk(r[1] == !phy, "R8 error flag", {31'b0, r[1]}, {31'b0, !phy});
            end else if (kind == 2'd0) begin
                rd(15, r); chk(r == {16'b0, val}, "R5 address stored", r, {16'b0, val});
            end
        end

        // R2 divider 3 gives 6 system clocks per MDC period
        pv_read = 1'b0;
        wr(12, 32'h0000_0300);
        wr(13, 32'h0000_0064);
        k = 0;
        wr(14, 32'h0000_5555);
        // R9 busy during frame, mirrored in data bit 31
        rd(12, r); chk(r[0] == 1'b1, "R9 status busy", r, 1);
        rd(14, r); chk(r[31] == 1'b1, "R9 data busy mirror", r, 32'h8000_5555);
        // R10 dropped writes while busy
        wr(14, 32'h0000_2222);
        wr(13, 32'h0000_FFFF);
        wr(15, 32'h0000_7777);
        wait_idle();
        chk((t_cur - t_prev) == 6 * CLK_P, "R2 mdc period", 32'(t_cur - t_prev), 6 * CLK_P);
        chk(k == 64, "R10 single frame", k, 64);
        rd(14, r); chk(r == 32'h0000_5555, "R10 data kept", r, 32'h5555);
        rd(13, r); chk(r == 32'h0000_0064, "R10 control kept", r, 32'h64);
        rd(15, r); chk(r == 32'h0000_8001, "R10 address kept", r, 32'h8001);

        // R11 address write in short-frame mode
        wr(12, 32'h0000_0100);
        k = 0;
        wr(15, 32'h0000_4321);
        repeat (20) @(negedge clk);
        chk(k == 0 && mdc == 1'b0, "R11 no frame", k, 0);
        rd(15, r); chk(r == 32'h0000_4321, "R11 address stored", r, 32'h4321);

        // R12 scan bit only stored
        wr(13, 32'h0000_0800);
        repeat (20) @(negedge clk);
        rd(12, r); chk(r[0] == 1'b0 && k == 0, "R12 no activity", r, 32'h100);
        rd(13, r); chk(r == 32'h0000_0800, "R12 scan readback", r, 32'h800);

        // R6 output steady while MDC high
        chk(hold_viol == 0, "R6 output hold", hold_viol, 0);

        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1'b1;
            tests = tests + 1;
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule